// File: doc/BRIEF.md
# Flash Transfer Chunking Engine

This block sits in front of a serial-flash sequencing controller and turns one software-sized transfer request into a series of cycles that the controller can legally run. A request carries a start address in flash, a total byte count, a direction (program or read) and a flag that says whether the cycle has a data phase at all. The engine first waits for the controller to go idle. It then sizes each piece, hands the address and the count to the controller over a simple request and completion handshake, and steps the address and the remaining count forward. When the count reaches zero, when the controller flags a blocked access, or when a wait runs out of time, it stops.

Each piece has two limits. It must end at or before the next 256-byte page edge, because many flash parts wrap or refuse writes that cross a page. It must also be one of the sizes the controller accepts: any count from 1 to 8, or a multiple of 8 up to 64. The data itself and the serial signalling live behind the handshake and are outside this block.

Top module: `spi_chunk_engine`

## Requirements
- R1: During and just after synchronous reset, `busy`, `done`, `err`, `cyc_req` and `err_code` are all low.
- R2: No issued data cycle crosses a 256-byte boundary. When the remaining count runs past the next boundary, the piece is cut so that it ends exactly on that boundary.
- R3: A candidate piece of 64 or more bytes is issued as 64. A piece of 9 to 63 bytes is rounded down to a multiple of 8, and a piece of 1 to 8 bytes is issued as is. `cyc_cnt_m1` carries the piece size minus one.
- R4: After each successful completion, the next address is the previous one plus the piece size and the remaining count drops by the same amount. Pieces are issued until the count is zero, and the request then ends with `done` high and `err_code` = 0 (none).
- R5: When `req_data_cycle` is low, or the length is zero, exactly one cycle is issued at the start address, with `cyc_data` = 0 and `cyc_cnt_m1` = 0.
- R6: Before the first piece, the engine waits until `ctl_in_progress` is low. No `cyc_req` is raised while that input is high.
- R7: If `ctl_in_progress` stays high, or `cyc_ack` fails to arrive, for `timeout_limit`+1 cycles of waiting, the request ends with `err_code` = 2 (timeout) and no further piece is issued. A completion that arrives on the last allowed cycle is still accepted.
- R8: A completion with `cyc_blocked` high ends the request at once with `err_code` = 1 (blocked), and no further piece is issued.
- R9: `busy` rises on the cycle after a start is accepted and falls on the same edge on which the one-cycle `done` pulse rises. A start presented while `busy` is high is ignored. `err` is high with `done` exactly when `err_code` is nonzero.
- R10: `cyc_write` on every issued cycle equals the `req_write` value of the request that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start pulse for a new request |
| req_addr | input | ADDR_W | Start flash address |
| req_len | input | LEN_W | Total byte count |
| req_write | input | 1 | Direction: 1 shifts data out to flash |
| req_data_cycle | input | 1 | Request has a data phase |
| timeout_limit | input | TMO_W | Wait limit in clock cycles |
| ctl_in_progress | input | 1 | Controller reports a cycle running |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request ended with an error |
| err_code | output | 2 | 0 none, 1 blocked, 2 timeout |
| cyc_req | output | 1 | One-cycle pulse: issue a piece |
| cyc_addr | output | ADDR_W | Piece start address |
| cyc_cnt_m1 | output | CNT_W | Piece size minus one |
| cyc_write | output | 1 | Piece direction |
| cyc_data | output | 1 | Piece has a data phase |
| cyc_ack | input | 1 | Controller completion strobe |
| cyc_blocked | input | 1 | Completion reported a blocked access |

## Verification
The completion strobe and the expiry of the wait timer can land on the same clock edge. The design gives the completion priority. The bench sets a small limit and a controller model that answers after an exact number of cycles. An answer on the last allowed cycle must finish cleanly with code 0. An answer one cycle later must end in a timeout with code 2. A second overlap, a fresh start pulse while a request is running, is checked by comparing the issued piece list against the one predicted for the first request alone.

// File: rtl/spi_chunk_pkg.sv
package spi_chunk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_IDLE = 2'd1,
    ST_ISSUE     = 2'd2,
    ST_WAIT_ACK  = 2'd3
  } chunk_state_t;

  typedef enum logic [1:0] {
    XFER_OK      = 2'd0,
    XFER_BLOCKED = 2'd1,
    XFER_TIMEOUT = 2'd2
  } xfer_status_t;

endpackage

// File: rtl/chunk_sizer.sv
module chunk_sizer #(
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_CHUNK  = 64,
  parameter int STEP       = 8,
  localparam int PAGE_BITS = $clog2(PAGE_BYTES),
  localparam int STEP_BITS = $clog2(STEP),
  localparam int CHUNK_W   = $clog2(MAX_CHUNK) + 1
) (
  input  logic [PAGE_BITS-1:0] addr_lo,
  input  logic [LEN_W-1:0]     remain,
  output logic [CHUNK_W-1:0]   chunk
);

  logic [LEN_W-1:0] room;
  logic [LEN_W-1:0] cand;

  // bytes left before the next page edge (1 .. PAGE_BYTES)
  assign room = LEN_W'(PAGE_BYTES) - LEN_W'(addr_lo);
  assign cand = (remain < room) ? remain : room;

  always_comb begin
    if (cand >= LEN_W'(MAX_CHUNK)) begin
      chunk = CHUNK_W'(MAX_CHUNK);
    end else if (cand > LEN_W'(STEP)) begin
      chunk = CHUNK_W'({cand[LEN_W-1:STEP_BITS], {STEP_BITS{1'b0}}});
    end else begin
      chunk = CHUNK_W'(cand);
    end
  end

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run && (cnt != limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt == limit);

endmodule

// File: rtl/spi_chunk_engine.sv
module spi_chunk_engine
  import spi_chunk_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_CHUNK  = 64,
  parameter int STEP       = 8,
  parameter int TMO_W      = 16,
  localparam int PAGE_BITS = $clog2(PAGE_BYTES),
  localparam int CNT_W     = $clog2(MAX_CHUNK),
  localparam int CHUNK_W   = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic              req_data_cycle,
  input  logic [TMO_W-1:0]  timeout_limit,
  input  logic              ctl_in_progress,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic              cyc_req,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [CNT_W-1:0]  cyc_cnt_m1,
  output logic              cyc_write,
  output logic              cyc_data,
  input  logic              cyc_ack,
  input  logic              cyc_blocked
);

  chunk_state_t       state;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   remain;
  logic               dir_q;
  logic               data_q;
  logic [CHUNK_W-1:0] chunk_q;
  logic [CHUNK_W-1:0] chunk_len;
  logic               tmr_clear;
  logic               tmr_run;
  logic               tmr_expired;

  chunk_sizer #(
    .LEN_W      (LEN_W),
    .PAGE_BYTES (PAGE_BYTES),
    .MAX_CHUNK  (MAX_CHUNK),
    .STEP       (STEP)
  ) sizer_i (
    .addr_lo (cur_addr[PAGE_BITS-1:0]),
    .remain  (remain),
    .chunk   (chunk_len)
  );

  assign tmr_clear = (state == ST_IDLE) || (state == ST_ISSUE);
  assign tmr_run   = ((state == ST_WAIT_IDLE) && ctl_in_progress) ||
                     ((state == ST_WAIT_ACK) && !cyc_ack);

  wait_timer #(
    .TMO_W (TMO_W)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .run     (tmr_run),
    .limit   (timeout_limit),
    .expired (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      remain     <= '0;
      dir_q      <= 1'b0;
      data_q     <= 1'b0;
      chunk_q    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      err_code   <= XFER_OK;
      cyc_req    <= 1'b0;
      cyc_addr   <= '0;
      cyc_cnt_m1 <= '0;
      cyc_write  <= 1'b0;
      cyc_data   <= 1'b0;
    end else begin
      done    <= 1'b0;
      cyc_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr <= req_addr;
            remain   <= req_data_cycle ? req_len : '0;
            data_q   <= req_data_cycle && (req_len != '0);
            dir_q    <= req_write;
            busy     <= 1'b1;
            err      <= 1'b0;
            err_code <= XFER_OK;
            state    <= ST_WAIT_IDLE;
          end
        end
        ST_WAIT_IDLE: begin
          if (!ctl_in_progress) begin
            state <= ST_ISSUE;
          end else if (tmr_expired) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            err      <= 1'b1;
            err_code <= XFER_TIMEOUT;
            state    <= ST_IDLE;
          end
        end
        ST_ISSUE: begin
          cyc_req    <= 1'b1;
          cyc_addr   <= cur_addr;
          cyc_cnt_m1 <= data_q ? CNT_W'(chunk_len - 1'b1) : '0;
          cyc_write  <= dir_q;
          cyc_data   <= data_q;
          chunk_q    <= data_q ? chunk_len : '0;
          state      <= ST_WAIT_ACK;
        end
        ST_WAIT_ACK: begin
          if (cyc_ack) begin
            if (cyc_blocked) begin
              busy     <= 1'b0;
              done     <= 1'b1;
              err      <= 1'b1;
              err_code <= XFER_BLOCKED;
              state    <= ST_IDLE;
            end else begin
              cur_addr <= cur_addr + ADDR_W'(chunk_q);
              remain   <= remain - LEN_W'(chunk_q);
              if (remain == LEN_W'(chunk_q)) begin
                busy     <= 1'b0;
                done     <= 1'b1;
                err      <= 1'b0;
                err_code <= XFER_OK;
                state    <= ST_IDLE;
              end else begin
                state <= ST_ISSUE;
              end
            end
          end else if (tmr_expired) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            err      <= 1'b1;
            err_code <= XFER_TIMEOUT;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_chunk_engine_chk.sv
module spi_chunk_engine_chk #(
  parameter int PAGE_BYTES = 256,
  parameter int STEP       = 8,
  parameter int CNT_W      = 6,
  localparam int PAGE_BITS = $clog2(PAGE_BYTES),
  localparam int STEP_BITS = $clog2(STEP)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 busy,
  input logic                 done,
  input logic                 err,
  input logic [1:0]           err_code,
  input logic                 cyc_req,
  input logic [PAGE_BITS-1:0] cyc_addr_lo,
  input logic [CNT_W-1:0]     cyc_cnt_m1,
  input logic                 cyc_data,
  input logic                 ctl_in_progress
);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9
  err_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (err == (err_code != 2'd0)));

  // R4
  req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_req |-> busy);

  // R2
  page_cross_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_req && cyc_data) |-> ((32'(cyc_addr_lo) + 32'(cyc_cnt_m1)) < PAGE_BYTES));

  // R3
  legal_size_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_req && cyc_data) |->
      ((32'(cyc_cnt_m1) < STEP) || (cyc_cnt_m1[STEP_BITS-1:0] == {STEP_BITS{1'b1}})));

  // R5
  nodata_count_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_req && !cyc_data) |-> (cyc_cnt_m1 == '0));

  // R6
  idle_before_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_req) && $rose(busy) |-> 1'b0);

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_req |=> !cyc_req);

  // R6: the first piece can only follow an observed idle controller
  wait_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && ctl_in_progress) |=> !cyc_req);

endmodule

bind spi_chunk_engine spi_chunk_engine_chk #(
  .PAGE_BYTES (PAGE_BYTES),
  .STEP       (STEP),
  .CNT_W      (CNT_W)
) chk_i (
  .clk             (clk),
  .rst             (rst),
  .busy            (busy),
  .done            (done),
  .err             (err),
  .err_code        (err_code),
  .cyc_req         (cyc_req),
  .cyc_addr_lo     (cyc_addr[PAGE_BITS-1:0]),
  .cyc_cnt_m1      (cyc_cnt_m1),
  .cyc_data        (cyc_data),
  .ctl_in_progress (ctl_in_progress)
);

// File: tb/spi_chunk_engine_tb_top.sv
`timescale 1ns/1ps
module spi_chunk_engine_tb_top;

  localparam int ADDR_W = 24;
  localparam int LEN_W  = 16;
  localparam int TMO_W  = 16;
  localparam int CNT_W  = 6;
  localparam int NVEC   = 6;

  // {address, length}
  localparam logic [39:0] VEC [NVEC] = '{
    {24'h000000, 16'd1},
    {24'h0000F0, 16'd40},
    {24'h000010, 16'd200},
    {24'h0000FD, 16'd20},
    {24'h123456, 16'd13},
    {24'h0001C0, 16'd64}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_write = 1'b0;
  logic              req_data_cycle = 1'b0;
  logic [TMO_W-1:0]  timeout_limit = 16'd1000;
  logic              ctl_in_progress = 1'b0;
  logic              busy, done, err;
  logic [1:0]        err_code;
  logic              cyc_req;
  logic [ADDR_W-1:0] cyc_addr;
  logic [CNT_W-1:0]  cyc_cnt_m1;
  logic              cyc_write, cyc_data;
  logic              cyc_ack = 1'b0;
  logic              cyc_blocked = 1'b0;

  int checks = 0;
  int fails  = 0;

  int got_addr [64];
  int got_len  [64];
  int got_wr   [64];
  int got_ctl  [64];
  int n_got = 0;
  int exp_addr [64];
  int exp_len  [64];
  int n_exp = 0;

  int ack_gap = 2;
  int no_ack  = 0;
  int blk_idx = -1;

  always #5 clk = ~clk;

  spi_chunk_engine dut_i (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .req_len         (req_len),
    .req_write       (req_write),
    .req_data_cycle  (req_data_cycle),
    .timeout_limit   (timeout_limit),
    .ctl_in_progress (ctl_in_progress),
    .busy            (busy),
    .done            (done),
    .err             (err),
    .err_code        (err_code),
    .cyc_req         (cyc_req),
    .cyc_addr        (cyc_addr),
    .cyc_cnt_m1      (cyc_cnt_m1),
    .cyc_write       (cyc_write),
    .cyc_data        (cyc_data),
    .cyc_ack         (cyc_ack),
    .cyc_blocked     (cyc_blocked)
  );

  // controller model: records each piece, answers after ack_gap cycles
  initial begin
    forever begin
      @(negedge clk);
      if (cyc_req) begin
        if (n_got < 64) begin
          got_addr[n_got] = int'(cyc_addr);
          got_len[n_got]  = cyc_data ? int'(cyc_cnt_m1) + 1 : 0;
          got_wr[n_got]   = int'(cyc_write);
          got_ctl[n_got]  = int'(ctl_in_progress);
        end
        n_got = n_got + 1;
        if (no_ack == 0) begin
          repeat (ack_gap) @(negedge clk);
          cyc_ack     = 1'b1;
          cyc_blocked = ((n_got - 1) == blk_idx);
          @(negedge clk);
          cyc_ack     = 1'b0;
          cyc_blocked = 1'b0;
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    fails  = fails + 1;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic predict(input int a, input int n);
    int rem;
    int cur;
    int room;
    int piece;
    rem = n;
    cur = a;
    n_exp = 0;
    while (rem > 0) begin
      room  = 256 - (cur % 256);
      piece = (rem < room) ? rem : room;
      if (piece >= 64) piece = 64;
      else if (piece > 8) piece = (piece / 8) * 8;
      exp_addr[n_exp] = cur;
      exp_len[n_exp]  = piece;
      n_exp = n_exp + 1;
      cur = cur + piece;
      rem = rem - piece;
    end
  endtask

  task automatic run_req(input int a, input int n, input bit wr, input bit dc,
                         output int code);
    int guard;
    n_got = 0;
    @(negedge clk);
    req_addr       = ADDR_W'(a);
    req_len        = LEN_W'(n);
    req_write      = wr;
    req_data_cycle = dc;
    req_valid      = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard = guard + 1;
    end
    chk(done == 1'b1, "R9 done seen", int'(done), 1);
    code = int'(err_code);
    chk(err == (code != 0), "R9 err flag", int'(err), int'(code != 0));
    repeat (6) @(negedge clk);
  endtask

  task automatic compare_pieces(input bit wr);
    chk(n_got == n_exp, "R4 piece count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_addr[i] == exp_addr[i], "R2 R4 piece address", got_addr[i], exp_addr[i]);
      chk(got_len[i] == exp_len[i], "R2 R3 piece size", got_len[i], exp_len[i]);
      chk(got_wr[i] == int'(wr), "R10 direction", got_wr[i], int'(wr));
    end
  endtask

  initial begin
    int code;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, err, cyc_req, err_code} == 6'b0, "R1 reset outputs",
        int'({busy, done, err, cyc_req, err_code}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, cyc_req} == 3'b0, "R1 after release", int'({busy, done, cyc_req}), 0);

    // table of requests
    for (int v = 0; v < NVEC; v++) begin
      predict(int'(VEC[v][39:16]), int'(VEC[v][15:0]));
      run_req(int'(VEC[v][39:16]), int'(VEC[v][15:0]), v[0], 1'b1, code);
      compare_pieces(v[0]);
      chk(code == 0, "R4 clean finish", code, 0);
    end

    // R5 no data phase
    run_req(32'h40, 100, 1'b1, 1'b0, code);
    chk(n_got == 1, "R5 single cycle", n_got, 1);
    chk(got_len[0] == 0 && got_addr[0] == 32'h40, "R5 zero count at start", got_len[0], 0);
    chk(code == 0, "R5 status", code, 0);
    run_req(32'h80, 0, 1'b0, 1'b1, code);
    chk(n_got == 1 && got_len[0] == 0, "R5 zero length", n_got, 1);

    // R6 wait for idle controller
    ctl_in_progress = 1'b1;
    fork
      run_req(32'h10, 4, 1'b0, 1'b1, code);
      begin
        repeat (8) @(negedge clk);
        ctl_in_progress = 1'b0;
      end
    join
    chk(n_got == 1 && got_ctl[0] == 0, "R6 piece after idle", got_ctl[0], 0);
    chk(code == 0, "R6 status", code, 0);

    // R7 timeout while controller stays busy
    timeout_limit   = 16'd4;
    ctl_in_progress = 1'b1;
    run_req(32'h0, 16, 1'b0, 1'b1, code);
    chk(code == 2, "R7 idle timeout code", code, 2);
    chk(n_got == 0, "R7 no piece after timeout", n_got, 0);
    ctl_in_progress = 1'b0;

    // R7 completion on last allowed cycle vs one late
    timeout_limit = 16'd3;
    ack_gap = 3;
    run_req(32'h0, 4, 1'b0, 1'b1, code);
    chk(code == 0, "R7 ack on final cycle wins", code, 0);
    ack_gap = 4;
    run_req(32'h0, 4, 1'b0, 1'b1, code);
    chk(code == 2, "R7 late ack times out", code, 2);
    repeat (10) @(negedge clk);
    ack_gap = 2;
    no_ack  = 1;
    run_req(32'h0, 100, 1'b0, 1'b1, code);
    chk(code == 2 && n_got == 1, "R7 missing ack", code, 2);
    no_ack = 0;
    timeout_limit = 16'd1000;

    // R8 blocked completion on second piece
    blk_idx = 1;
    run_req(32'h0, 200, 1'b1, 1'b1, code);
    chk(code == 1, "R8 blocked code", code, 1);
    chk(n_got == 2, "R8 stops after blocked piece", n_got, 2);
    blk_idx = -1;

    // R9 start while busy is ignored
    predict(32'h20, 150);
    n_got = 0;
    @(negedge clk);
    req_addr = 24'h000300; req_len = 16'd5; req_write = 1'b0; req_data_cycle = 1'b1;
    req_addr = 24'h000020; req_len = 16'd150;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 1'b1, "R9 busy during request", int'(busy), 1);
    req_addr = 24'h000300; req_len = 16'd5; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int guard;
      guard = 0;
      while (!done && guard < 20000) begin
        @(negedge clk);
        guard = guard + 1;
      end
    end
    repeat (6) @(negedge clk);
    compare_pieces(1'b0);
    chk(busy == 1'b0, "R9 idle after second start ignored", int'(busy), 0);

    summary();
    $finish;
  end

endmodule